// File: doc/BRIEF.md
# Conversion Result Offset and Justification Formatter

This block turns a raw 12-bit unsigned conversion result into the 16-bit word that is stored for readout. Each result arrives with a valid strobe, a group tag and a slot index. The group tag marks the result as either a regular conversion or a priority (injected) conversion. Regular results pass through unchanged in value. Injected results have a per-slot calibration offset subtracted, so the stored value is signed and may be negative.

A single alignment control bit places the value either at the bottom of the 16-bit word (right-justified) or at the top (left-justified). For signed injected values, the bits not occupied by data carry copies of the sign. The formatted word and its valid strobe are registered. The strobe appears one clock after the input strobe. The word holds its value between results.

Top module: `adc_result_fmt`

## Requirements
- R1: While rst_ni is low, and after it is released until the first accepted result, valid_o is 0 and data_o is 16'h0000.
- R2: valid_o is 1 exactly in the clock cycle after a cycle in which valid_i was 1, and 0 otherwise.
- R3: A regular result (grp_i = 0) with align_i = 0 is stored as {4'b0000, result}.
- R4: A regular result with align_i = 1 is stored as {result, 4'b0000}.
- R5: An injected result (grp_i = 1) with align_i = 0 is stored as the 13-bit signed difference result minus offset, sign-extended to 16 bits. Bits [15:12] are then all equal to the sign.
- R6: An injected result with align_i = 1 is stored with the sign of the difference in bit 15, the difference's low 12 bits in bits [14:3], and zeros in bits [2:0].
- R7: The offset for slot k is offsets_i[12*k+11 : 12*k], selected by slot_i = k. Offsets have no effect on regular results, whatever their value.
- R8: In a cycle with valid_i = 0, data_o keeps its previous value on the next clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| valid_i | input | 1 | Result strobe |
| result_i | input | 12 | Unsigned conversion result |
| grp_i | input | 1 | 0 = regular, 1 = injected |
| slot_i | input | 2 | Injected slot index selecting the offset |
| align_i | input | 1 | 0 = right-justified, 1 = left-justified |
| offsets_i | input | 48 | Four 12-bit offsets, slot k in bits [12k+11:12k] |
| data_o | output | 16 | Formatted result word |
| valid_o | output | 1 | Result word strobe, one cycle after valid_i |

## Verification
The assertions assume that grp_i, slot_i, align_i, result_i and offsets_i are stable and known whenever valid_i is high. They also assume that offsets change only in cycles without a result. The driver changes all inputs once per cycle on the falling edge and never touches offsets_i while a result is in flight. The stimulus covers the extreme differences +4095 and -4095, zero, every slot, and regular results paired with nonzero offsets. Idle gaps between results exercise the hold behaviour.

// File: rtl/fmt_pkg.sv
package fmt_pkg;
  typedef enum logic {
    GRP_REG = 1'b0,
    GRP_INJ = 1'b1
  } grp_e;
endpackage

// File: rtl/fmt_offset_mux.sv
module fmt_offset_mux #(
  parameter int DATA_W    = 12,
  parameter int NUM_SLOTS = 4,
  localparam int SLOT_W   = $clog2(NUM_SLOTS)
) (
  input  logic [NUM_SLOTS*DATA_W-1:0] offsets_i,
  input  logic [SLOT_W-1:0]           slot_i,
  output logic [DATA_W-1:0]           offset_o
);
  logic [DATA_W-1:0] ofs_arr [NUM_SLOTS];

  for (genvar k = 0; k < NUM_SLOTS; k++) begin : g_unpack
    assign ofs_arr[k] = offsets_i[k*DATA_W +: DATA_W];
  end

  assign offset_o = ofs_arr[slot_i];
endmodule

// File: rtl/fmt_offset_sub.sv
module fmt_offset_sub #(
  parameter int DATA_W = 12
) (
  input  logic [DATA_W-1:0]        result_i,
  input  logic [DATA_W-1:0]        offset_i,
  output logic signed [DATA_W:0]   diff_o
);
  // one extra bit keeps the full -(2^N-1)..(2^N-1) range
  assign diff_o = $signed({1'b0, result_i}) - $signed({1'b0, offset_i});
endmodule

// File: rtl/fmt_justify.sv
module fmt_justify #(
  parameter int DATA_W  = 12,
  parameter int OUT_W   = 16,
  localparam int PAD_W  = OUT_W - DATA_W
) (
  input  logic                   inj_i,
  input  logic                   left_i,
  input  logic [DATA_W-1:0]      raw_i,
  input  logic signed [DATA_W:0] diff_i,
  output logic [OUT_W-1:0]       word_o
);
  always_comb begin
    unique case ({inj_i, left_i})
      2'b00:   word_o = {{PAD_W{1'b0}}, raw_i};
      2'b01:   word_o = {raw_i, {PAD_W{1'b0}}};
      2'b10:   word_o = {{(PAD_W-1){diff_i[DATA_W]}}, diff_i};
      default: word_o = {diff_i, {(PAD_W-1){1'b0}}};
    endcase
  end
endmodule

// File: rtl/adc_result_fmt.sv
module adc_result_fmt #(
  parameter int DATA_W    = 12,
  parameter int OUT_W     = 16,
  parameter int NUM_SLOTS = 4,
  localparam int SLOT_W   = $clog2(NUM_SLOTS)
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        valid_i,
  input  logic [DATA_W-1:0]           result_i,
  input  logic                        grp_i,
  input  logic [SLOT_W-1:0]           slot_i,
  input  logic                        align_i,
  input  logic [NUM_SLOTS*DATA_W-1:0] offsets_i,
  output logic [OUT_W-1:0]            data_o,
  output logic                        valid_o
);
  import fmt_pkg::*;

  localparam int PAD_W = OUT_W - DATA_W;

  logic [DATA_W-1:0]        offset_sel;
  logic signed [DATA_W:0]   diff;
  logic [OUT_W-1:0]         word_d;
  logic                     is_inj;

  assign is_inj = (grp_e'(grp_i) == GRP_INJ);

  fmt_offset_mux #(.DATA_W(DATA_W), .NUM_SLOTS(NUM_SLOTS)) u_mux (
    .offsets_i (offsets_i),
    .slot_i    (slot_i),
    .offset_o  (offset_sel)
  );

  fmt_offset_sub #(.DATA_W(DATA_W)) u_sub (
    .result_i (result_i),
    .offset_i (offset_sel),
    .diff_o   (diff)
  );

  fmt_justify #(.DATA_W(DATA_W), .OUT_W(OUT_W)) u_just (
    .inj_i  (is_inj),
    .left_i (align_i),
    .raw_i  (result_i),
    .diff_i (diff),
    .word_o (word_d)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      data_o  <= '0;
    end else begin
      valid_o <= valid_i;
      if (valid_i) data_o <= word_d;
    end
  end

  AST_VALID_FOLLOWS: assert property (@(posedge clk_i) disable iff (!rst_ni) valid_i |=> valid_o); // R2
  AST_VALID_DROPS: assert property (@(posedge clk_i) disable iff (!rst_ni) !valid_i |=> !valid_o); // R2
  AST_REG_RIGHT_PAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && !grp_i && !align_i) |=> (data_o[OUT_W-1:DATA_W] == '0)); // R3
  AST_REG_LEFT_PAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && !grp_i && align_i) |=> (data_o[PAD_W-1:0] == '0)); // R4
  AST_INJ_SIGN_EXT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && grp_i && !align_i) |=>
      (data_o[OUT_W-1:DATA_W] == '0 || data_o[OUT_W-1:DATA_W] == '1)); // R5
  AST_INJ_LEFT_PAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && grp_i && align_i) |=> (data_o[PAD_W-2:0] == '0)); // R6
  AST_HOLD_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> $stable(data_o)); // R8
endmodule

// File: tb/adc_result_fmt_tb.sv
module adc_result_fmt_tb;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        valid_i = 1'b0;
  logic [11:0] result_i = '0;
  logic        grp_i = 1'b0;
  logic [1:0]  slot_i = '0;
  logic        align_i = 1'b0;
  logic [47:0] offsets_i = '0;
  logic [15:0] data_o;
  logic        valid_o;

  int checks = 0;
  int fails = 0;
  logic [15:0] exp_q[$];
  string       tag_q[$];
  logic [15:0] last_word = '0;
  bit          done = 1'b0;

  always #10 clk_i = ~clk_i;  // 50 MHz

  adc_result_fmt u_dut (.*);

  function automatic logic [15:0] model(logic g, logic [11:0] r, logic [11:0] o, logic a);
    int d;
    if (g) begin
      d = int'(r) - int'(o);
      return a ? 16'(d * 8) : 16'(d);
    end
    return a ? {r, 4'h0} : {4'h0, r};
  endfunction

  task automatic check(string tag, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  task automatic send(string tag, logic g, logic [11:0] r, logic [1:0] s, logic a);
    logic [15:0] e;
    @(negedge clk_i);
    valid_i = 1'b1; grp_i = g; result_i = r; slot_i = s; align_i = a;
    e = model(g, r, offsets_i[s*12 +: 12], a);
    exp_q.push_back(e);
    tag_q.push_back(tag);
    last_word = e;
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk_i);
      valid_i = 1'b0;
      result_i = 12'(i * 37 + 5);
      grp_i = ~grp_i;
    end
  endtask

  // monitor: compare each produced word against the scoreboard
  always @(negedge clk_i) begin
    if (rst_ni && !done) begin
      if (valid_o) begin
        if (exp_q.size() == 0) begin
          checks++; fails++;
          $display("FAIL R2: got unexpected valid_o expected none");
        end else begin
          check(tag_q.pop_front(), data_o, exp_q.pop_front());
        end
      end
    end
  end

  initial begin
    int cyc = 0;
    while (!done) begin
      @(posedge clk_i);
      cyc++;
      if (cyc > 20000) begin
        fails++; checks++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
      end
    end
  end

  initial begin
    repeat (3) @(negedge clk_i);
    check("R1 data", data_o, 16'h0000);
    check("R1 valid", {15'h0, valid_o}, 16'h0000);
    rst_ni = 1'b1;
    offsets_i = {12'h7FF, 12'h180, 12'hFFF, 12'h000}; // slots 3..0
    idle(2);
    check("R1 data after release", data_o, 16'h0000);

    send("R3", 1'b0, 12'hABC, 2'd1, 1'b0);
    send("R4", 1'b0, 12'hABC, 2'd1, 1'b0 ^ 1'b1);
    send("R7 regular ignores offset", 1'b0, 12'h123, 2'd3, 1'b0);
    send("R5 slot0 +4095", 1'b1, 12'hFFF, 2'd0, 1'b0);
    send("R6 slot0 +4095", 1'b1, 12'hFFF, 2'd0, 1'b1);
    send("R5 slot1 -4095", 1'b1, 12'h000, 2'd1, 1'b0);
    send("R6 slot1 -4095", 1'b1, 12'h000, 2'd1, 1'b1);
    send("R5 slot2 negative", 1'b1, 12'h100, 2'd2, 1'b0);
    send("R6 slot2 negative", 1'b1, 12'h100, 2'd2, 1'b1);
    send("R7 slot3 zero diff", 1'b1, 12'h7FF, 2'd3, 1'b0);
    idle(1);
    @(negedge clk_i);
    check("R8 hold", data_o, last_word);
    check("R2 idle valid", {15'h0, valid_o}, 16'h0000);
    idle(3);
    check("R8 hold long", data_o, last_word);

    // sweep: new offsets changed only while idle
    for (int pass = 0; pass < 8; pass++) begin
      idle(2);
      @(negedge clk_i);
      offsets_i = {$urandom(), $urandom()};
      for (int j = 0; j < 24; j++) begin
        logic g;
        logic a;
        g = j[0];
        a = j[1];
        send(g ? (a ? "R6" : "R5") : (a ? "R4" : "R3"),
             g, 12'($urandom()), 2'(j >> 2), a);
        if (j % 5 == 4) idle(1);
      end
    end
    idle(3);
    check("R2 all results delivered", 16'(exp_q.size()), 16'h0000);
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule